// File: doc/BRIEF.md
# Frame-Synchronized Command Sequencer

This block holds register-write commands that must take effect at a chosen video frame and issues them at the start of that frame. The storage is split into 16 frame pages of 64 command slots each. A host pushes commands through a valid/ready input stream. Each command carries an address/data pair and a frame selector, which is either an absolute frame number modulo 16 or an offset from the frame that is current. A relative offset of zero is the "as soon as possible" case: that command skips the pages and goes straight to the output.

Each start-of-frame pulse moves the frame counter forward by one and drains the page for the new frame. The page is read out one command per accepted cycle, in the order the commands were written, on a valid/ready output stream. A command that arrives for the current page after its frame has started is still issued before the next page is activated. A start-of-frame pulse that arrives during a drain is held until the drain has finished.

Back-pressure rules: the output stream moves a command only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the command on the output is held and nothing is lost. On the input stream, a stored (paged) command is accepted whenever `in_ready` is high. `in_ready` drops only in the cycle a page switch takes place. An immediate command is accepted only when no page is being drained and `out_ready` is high. In that case it passes combinationally to the output in the same cycle.

Top module: `frame_cmd_seq`

## Requirements
- R1: After reset `frame_num` is 0, `out_valid` is 0, `overflow` is 0 and `in_ready` is 1.
- R2: Each start-of-frame pulse that is acted on increments `frame_num` by one, modulo 16. A command written with `in_rel`=0 and `in_frame`=F is issued while `frame_num` equals F.
- R3: A command written with `in_rel`=1 and a nonzero `in_frame`=N is placed in page (`frame_num`+N) mod 16, with wrap-around.
- R4: A command written with `in_rel`=1 and `in_frame`=0 appears on `out_addr`/`out_data` with `out_valid` high in the same cycle, without waiting for a frame start.
- R5: The commands of one page are issued in the order they were written, one per cycle while `out_ready` is high.
- R6: A command written to the current page after its frame has started is issued before `frame_num` next advances.
- R7: While `out_ready` is low during a drain, `out_valid` stays high and the output command does not change.
- R8: A stored command aimed at a page that already holds 64 commands is dropped and sets `overflow`, which stays high until reset. The 64 commands already stored are still issued.
- R9: After a page has been drained it is empty. It issues nothing when its frame comes round again 16 frames later unless new commands were written to it.
- R10: While a page drain is in progress, an immediate command sees `in_ready` low.
- R11: A start-of-frame pulse that arrives during a drain does not advance `frame_num` at once. `frame_num` advances as soon as the drain finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse from the sensor |
| in_valid | input | 1 | Host command valid |
| in_ready | output | 1 | Host command accepted this cycle |
| in_rel | input | 1 | 1: `in_frame` is an offset from the current frame; 0: absolute frame |
| in_frame | input | 4 | Frame number or offset (offset 0 = immediate) |
| in_addr | input | ADDR_W | Register address of the command |
| in_data | input | DATA_W | Register data of the command |
| out_valid | output | 1 | Command available on the issue port |
| out_ready | input | 1 | Downstream takes the command |
| out_addr | output | ADDR_W | Issued register address |
| out_data | output | DATA_W | Issued register data |
| frame_num | output | 4 | Current frame number modulo 16 |
| overflow | output | 1 | Sticky flag: a write to a full page was dropped |

## Verification
A stale read pointer or a page count that was not cleared shows up as repeated or missing commands. The failure appears either in the same frame or exactly 16 frames later, when the page is reused. The bench therefore cycles a drained page through a full turn of the frame counter. A lost pending start-of-frame shows up as a `frame_num` that lags by one once the stalled drain is released. Bad page arithmetic shows up as a command issued under the wrong `frame_num`. Every issued command is logged together with the frame in which it was issued.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  // Which source drives the issue port in a given cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PAGE = 2'd1,
    SRC_IMM  = 2'd2
  } issue_src_e;
endpackage

// File: rtl/fcs_page_store.sv
module fcs_page_store #(
  parameter int PAGES  = 16,
  parameter int SLOTS  = 64,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(PAGES)-1:0] wr_page,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     wr_full,
  input  logic                     clr_en,
  input  logic [$clog2(PAGES)-1:0] clr_page,
  input  logic [$clog2(PAGES)-1:0] rd_page,
  input  logic [$clog2(SLOTS)-1:0] rd_slot,
  output logic [$clog2(SLOTS):0]   rd_cnt,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int PW    = $clog2(PAGES);
  localparam int SW    = $clog2(SLOTS);
  localparam int CW    = SW + 1;
  localparam int EW    = ADDR_W + DATA_W;
  localparam int DEPTH = PAGES * SLOTS;

  logic [CW-1:0]    cnt_q [PAGES];
  logic [EW-1:0]    mem_q [DEPTH];
  logic [PW+SW-1:0] wr_idx;
  logic [PW+SW-1:0] rd_idx;

  assign wr_full = (cnt_q[wr_page] == CW'(SLOTS));
  assign wr_idx  = {wr_page, cnt_q[wr_page][SW-1:0]};
  assign rd_idx  = {rd_page, rd_slot};
  assign rd_cnt  = cnt_q[rd_page];
  assign {rd_addr, rd_data} = mem_q[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en && !wr_full) mem_q[wr_idx] <= {wr_addr, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++) cnt_q[p] <= '0;
    end else begin
      if (wr_en && !wr_full) cnt_q[wr_page] <= cnt_q[wr_page] + CW'(1);
      if (clr_en) cnt_q[clr_page] <= '0;
    end
  end
endmodule

// File: rtl/fcs_frame_ctrl.sv
module fcs_frame_ctrl #(
  parameter int PAGES = 16,
  parameter int SLOTS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sof,
  input  logic [$clog2(SLOTS):0]   cur_cnt,
  input  logic                     pop,
  output logic [$clog2(PAGES)-1:0] cur_page,
  output logic [$clog2(SLOTS):0]   rd_ptr,
  output logic                     draining,
  output logic                     advance
);
  localparam int PW = $clog2(PAGES);
  localparam int CW = $clog2(SLOTS) + 1;

  logic pend_q;
  logic sof_req;

  assign draining = (rd_ptr != cur_cnt);
  assign sof_req  = sof | pend_q;
  assign advance  = sof_req & ~draining;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_page <= '0;
      rd_ptr   <= '0;
      pend_q   <= 1'b0;
    end else begin
      pend_q <= sof_req & ~advance;
      if (advance) begin
        cur_page <= cur_page + PW'(1);
        rd_ptr   <= '0;
      end else if (pop) begin
        rd_ptr <= rd_ptr + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fcs_issue_mux.sv
module fcs_issue_mux
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              draining,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [DATA_W-1:0] pg_data,
  input  logic              imm_valid,
  input  logic [ADDR_W-1:0] imm_addr,
  input  logic [DATA_W-1:0] imm_data,
  input  logic              out_ready,
  output logic              imm_ready,
  output logic              pop,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  issue_src_e src;

  always_comb begin
    if (draining)       src = SRC_PAGE;
    else if (imm_valid) src = SRC_IMM;
    else                src = SRC_NONE;
  end

  always_comb begin
    out_valid = (src != SRC_NONE);
    unique case (src)
      SRC_PAGE: begin out_addr = pg_addr;  out_data = pg_data;  end
      SRC_IMM:  begin out_addr = imm_addr; out_data = imm_data; end
      default:  begin out_addr = '0;       out_data = '0;       end
    endcase
  end

  assign pop       = (src == SRC_PAGE) & out_ready;
  assign imm_ready = ~draining & out_ready;
endmodule

// File: rtl/frame_cmd_seq.sv
module frame_cmd_seq #(
  parameter int PAGES  = 16,
  parameter int SLOTS  = 64,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sof,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_rel,
  input  logic [$clog2(PAGES)-1:0] in_frame,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ADDR_W-1:0]        out_addr,
  output logic [DATA_W-1:0]        out_data,
  output logic [$clog2(PAGES)-1:0] frame_num,
  output logic                     overflow
);
  localparam int PW = $clog2(PAGES);
  localparam int SW = $clog2(SLOTS);
  localparam int CW = SW + 1;

  logic          is_imm;
  logic [PW-1:0] tgt_page;
  logic          wr_en;
  logic          wr_full;
  logic [CW-1:0] cur_cnt;
  logic [CW-1:0] rd_ptr;
  logic          draining;
  logic          advance;
  logic          pop;
  logic          imm_ready;
  logic [ADDR_W-1:0] pg_addr;
  logic [DATA_W-1:0] pg_data;
  logic          ovf_q;

  assign is_imm   = in_rel & (in_frame == '0);
  assign tgt_page = in_rel ? (frame_num + in_frame) : in_frame;
  assign in_ready = is_imm ? imm_ready : ~advance;
  assign wr_en    = in_valid & in_ready & ~is_imm;
  assign overflow = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 ovf_q <= 1'b0;
    else if (wr_en && wr_full)  ovf_q <= 1'b1;
  end

  fcs_page_store #(
    .PAGES(PAGES), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_page  (tgt_page),
    .wr_addr  (in_addr),
    .wr_data  (in_data),
    .wr_full  (wr_full),
    .clr_en   (advance),
    .clr_page (frame_num),
    .rd_page  (frame_num),
    .rd_slot  (rd_ptr[SW-1:0]),
    .rd_cnt   (cur_cnt),
    .rd_addr  (pg_addr),
    .rd_data  (pg_data)
  );

  fcs_frame_ctrl #(
    .PAGES(PAGES), .SLOTS(SLOTS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof      (sof),
    .cur_cnt  (cur_cnt),
    .pop      (pop),
    .cur_page (frame_num),
    .rd_ptr   (rd_ptr),
    .draining (draining),
    .advance  (advance)
  );

  fcs_issue_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_mux (
    .draining  (draining),
    .pg_addr   (pg_addr),
    .pg_data   (pg_data),
    .imm_valid (in_valid & is_imm),
    .imm_addr  (in_addr),
    .imm_data  (in_data),
    .out_ready (out_ready),
    .imm_ready (imm_ready),
    .pop       (pop),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_data  (out_data)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int PW = 4,
  parameter int CW = 7,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] frame_num,
  input logic          overflow,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_rel,
  input logic [PW-1:0] in_frame,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [DW-1:0] out_data,
  input logic          draining,
  input logic [CW-1:0] rd_ptr,
  input logic [CW-1:0] cur_cnt
);
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_num != $past(frame_num)) |-> (frame_num == PW'($past(frame_num) + 1'b1))); // R2
  AST_ADV_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_num != $past(frame_num)) |-> !$past(draining)); // R6
  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_num != $past(frame_num)) |-> (rd_ptr == '0)); // R9
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= cur_cnt); // R5
  AST_IMM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && in_valid && in_rel && in_frame == '0) |-> !in_ready); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow); // R8
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data))); // R7
endmodule

bind frame_cmd_seq fcs_checker #(
  .PW(PW), .CW(CW), .AW(ADDR_W), .DW(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_num (frame_num),
  .overflow  (overflow),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_rel    (in_rel),
  .in_frame  (in_frame),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .draining  (draining),
  .rd_ptr    (rd_ptr),
  .cur_cnt   (cur_cnt)
);

// File: tb/frame_cmd_seq_tb.sv
module frame_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_rel = 1'b0;
  logic [3:0]  in_frame = '0;
  logic [15:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_addr;
  logic [31:0] out_data;
  logic [3:0]  frame_num;
  logic        overflow;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [47:0] log_ad [512];
  logic [3:0]  log_fr [512];
  int          n_log = 0;

  // table entry: {rel, frame, expected issue frame}; data = 100+i, addr = 16'h100+i
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 4'd2, 4'd2}, {1'b1, 4'd1, 4'd1}, {1'b0, 4'd0, 4'd0}, {1'b1, 4'd2, 4'd2},
    {1'b0, 4'd1, 4'd1}, {1'b1, 4'd3, 4'd3}, {1'b0, 4'd3, 4'd3}, {1'b0, 4'd0, 4'd0}
  };
  localparam int ORD [8] = '{2, 7, 1, 4, 0, 3, 5, 6};

  always #4 clk = ~clk;

  frame_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof),
    .in_valid(in_valid), .in_ready(in_ready), .in_rel(in_rel), .in_frame(in_frame),
    .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
    .frame_num(frame_num), .overflow(overflow)
  );

  // Record every issued command just before the edge that moves it
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && out_valid && out_ready && n_log < 512) begin
        log_ad[n_log] = {out_addr, out_data};
        log_fr[n_log] = frame_num;
        n_log++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called right after a negedge; returns right after a later negedge
  task automatic put(input bit rel, input logic [3:0] fr, input logic [15:0] a, input logic [31:0] d);
    in_rel = rel; in_frame = fr; in_addr = a; in_data = d; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_sof();
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    idle(3);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(frame_num == 0, "R1 frame_num", frame_num, 0);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(overflow == 0,  "R1 overflow", overflow, 0);
    check(in_ready == 1,  "R1 in_ready", in_ready, 1);
    @(negedge clk);

    // Table walk: all written while frame 0 is current (R2, R3, R5, R6)
    for (int i = 0; i < 8; i++)
      put(VEC[i][8], VEC[i][7:4], 16'h100 + 16'(i), 32'(100 + i));
    idle(4);
    for (int f = 0; f < 3; f++) begin
      pulse_sof();
      idle(4);
    end
    check(n_log == 8, "R2 table issue count", n_log, 8);
    for (int k = 0; k < 8; k++) begin
      check(log_ad[k][31:0] == 32'(100 + ORD[k]), "R5 table order", log_ad[k][31:0], 100 + ORD[k]);
      check(log_fr[k] == VEC[ORD[k]][3:0], "R2/R3/R6 table issue frame", log_fr[k], VEC[ORD[k]][3:0]);
    end

    // R4: immediate command appears in the same cycle
    base = n_log;
    in_rel = 1'b1; in_frame = 4'd0; in_addr = 16'hA5A5; in_data = 32'hCAFE; in_valid = 1'b1;
    #1;
    check(out_valid == 1 && in_ready == 1, "R4 immediate valid", out_valid, 1);
    check(out_data == 32'hCAFE, "R4 immediate data", out_data, 32'hCAFE);
    @(negedge clk);
    in_valid = 1'b0;
    idle(1);
    check(n_log == base + 1 && log_fr[base] == 4'd3, "R4 immediate issued once in frame 3", n_log - base, 1);

    // R7, R10, R11: stalled drain
    base = n_log;
    out_ready = 1'b0;
    put(1'b0, 4'd4, 16'h0004, 32'd400);
    put(1'b0, 4'd4, 16'h0004, 32'd401);
    pulse_sof();
    #1;
    check(frame_num == 4, "R2 frame after sof", frame_num, 4);
    check(out_valid == 1 && out_data == 32'd400, "R7 stalled head", out_data, 400);
    idle(2);
    #1;
    check(out_valid == 1 && out_data == 32'd400, "R7 held under stall", out_data, 400);
    @(negedge clk);
    in_rel = 1'b1; in_frame = 4'd0; in_addr = 16'h0BAD; in_data = 32'd999; in_valid = 1'b1;
    #1;
    check(in_ready == 0, "R10 immediate held during drain", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    pulse_sof();
    idle(2);
    #1;
    check(frame_num == 4, "R11 frame held during drain", frame_num, 4);
    @(negedge clk);
    out_ready = 1'b1;
    idle(5);
    check(frame_num == 5, "R11 pending sof applied", frame_num, 5);
    check(n_log == base + 2, "R7 no loss after stall", n_log - base, 2);
    check(log_ad[base][31:0] == 32'd400 && log_ad[base+1][31:0] == 32'd401,
          "R5 stalled page order", log_ad[base+1][31:0], 401);

    // R8: overflow on page 7
    base = n_log;
    for (int i = 0; i < 65; i++) put(1'b0, 4'd7, 16'h0007, 32'(1000 + i));
    #1;
    check(overflow == 1, "R8 overflow set", overflow, 1);
    @(negedge clk);
    pulse_sof();
    idle(2);
    pulse_sof();
    idle(80);
    check(n_log == base + 64, "R8 stored commands issued", n_log - base, 64);
    check(log_ad[base][31:0] == 32'd1000, "R8 first stored", log_ad[base][31:0], 1000);
    check(log_ad[base+63][31:0] == 32'd1063, "R8 last stored", log_ad[base+63][31:0], 1063);
    check(overflow == 1, "R8 overflow sticky", overflow, 1);

    // R9: full turn of frames, page 7 must stay empty
    base = n_log;
    for (int f = 0; f < 16; f++) begin
      pulse_sof();
      idle(2);
    end
    check(frame_num == 7, "R9 frame after full turn", frame_num, 7);
    check(n_log == base, "R9 drained page empty on reuse", n_log - base, 0);

    // R3: relative wrap, from frame 7 offset 10 lands in page 1
    base = n_log;
    put(1'b1, 4'd10, 16'h0031, 32'd3131);
    for (int f = 0; f < 10; f++) begin
      pulse_sof();
      idle(2);
    end
    check(n_log == base + 1, "R3 relative wrap issued once", n_log - base, 1);
    check(log_fr[base] == 4'd1, "R3 relative wrap frame", log_fr[base], 1);

    finish_run();
  end
endmodule